// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This unit computes one integer multiply or one integer divide at a time on either 32-bit or 64-bit operands. A request is a one-cycle start strobe carrying a 3-bit opcode and two operands. The unit then raises busy until the result is ready. It signals completion with a one-cycle done pulse and leaves the result on its outputs until the next result replaces it. The unit has no pipeline, so any start that arrives while an operation is in flight is dropped.

Multiplication has a fixed latency that depends on operand width. Division runs a shift-and-subtract loop that produces one quotient bit per cycle. Before the loop starts, the divisor is aligned under the leading one of the dividend, so leading zero quotient bits cost no cycles. This makes the total divide time track the number of significant quotient digits. That time is held between a floor and a ceiling. Signed work is done on magnitudes, and the signs are applied to the result at the end.

Top module: `imuldiv_unit`

## Requirements
- R1: Opcode bits are op[0]=divide, op[1]=signed, op[2]=64-bit. A 32-bit multiply uses opa[31:0] and opb[31:0], raises done 4 clock edges after the edge that accepts start, and returns the 64-bit product on res_lo with res_hi = 0.
- R2: A 64-bit multiply raises done 6 edges after acceptance and returns the 128-bit product as {res_hi, res_lo}.
- R3: A signed multiply returns the two's complement product of the sign-interpreted operands.
- R4: A divide returns the quotient on res_lo and the remainder on res_hi. In 32-bit mode both values sit in bits [31:0] and the upper 32 bits are zero.
- R5: Divide latency is clamp(9 + k, 21, 73) edges. k is 0 when the divisor magnitude is zero or is greater than the dividend magnitude. Otherwise k = bitlen(|a|) - bitlen(|b|) + 1.
- R6: A signed divide truncates the quotient toward zero, and the remainder takes the dividend's sign. The most negative value divided by -1 returns the most negative value with remainder 0.
- R7: Division by zero completes in 21 edges. It returns an all-ones quotient for the active width, and the remainder equals the dividend for the active width.
- R8: done is high for exactly one cycle per accepted operation. res_hi and res_lo change only in the cycle in which done is high.
- R9: busy is high from the accepting edge until done. A start that arrives while busy is ignored and does not change the result or the timing of the operation in flight.
- R10: After reset, busy, done, res_hi and res_lo are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| op | input | 3 | {64-bit, signed, divide} |
| opa | input | 64 | Multiplicand or dividend |
| opb | input | 64 | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 64 | Product high half, or remainder |
| res_lo | output | 64 | Product low half, or quotient |

## Verification
For each request, the bench works out from R1, R2, R5 and R7 how many edges after the accepting edge done is due: 4 or 6 for a multiply, and clamp(9 + k, 21, 73) for a divide, with k taken from the operand bit lengths. It stores that cycle number with the expected result. The monitor samples on the falling edge. It requires done and the correct result exactly at that cycle and flags any done pulse at any other cycle. The chosen divides land on the floor (21), on an intermediate value (41) and on the ceiling (73).

// File: rtl/imuldiv_unit.sv
module imuldiv_unit #(
  parameter int W         = 64,
  parameter int MUL_N_LAT = 4,
  parameter int MUL_W_LAT = 6,
  parameter int DIV_MIN   = 21,
  parameter int DIV_MAX   = 73,
  parameter int DIV_OVH   = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int H  = W / 2;
  localparam int IW = $clog2(W + 1);
  localparam int CW = $clog2(DIV_MAX + 1);
  localparam logic [W-1:0] LOMASK = {{(W-H){1'b0}}, {H{1'b1}}};

  function automatic logic [IW-1:0] bitlen(input logic [W-1:0] v);
    logic [IW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++)
      if (v[i]) n = IW'(i + 1);
    return n;
  endfunction

  wire div_i  = op[0];
  wire sgn_i  = op[1];
  wire wide_i = op[2];

  wire neg_a_i = sgn_i & (wide_i ? opa[W-1] : opa[H-1]);
  wire neg_b_i = sgn_i & (wide_i ? opb[W-1] : opb[H-1]);

  logic [W-1:0] na_w, nb_w;
  logic [H-1:0] na_n, nb_n;
  assign na_w = -opa;
  assign nb_w = -opb;
  assign na_n = -opa[H-1:0];
  assign nb_n = -opb[H-1:0];

  logic [W-1:0] mag_a, mag_b;
  assign mag_a = wide_i ? (neg_a_i ? na_w : opa)
                        : {{(W-H){1'b0}}, (neg_a_i ? na_n : opa[H-1:0])};
  assign mag_b = wide_i ? (neg_b_i ? nb_w : opb)
                        : {{(W-H){1'b0}}, (neg_b_i ? nb_n : opb[H-1:0])};

  logic [IW-1:0] k_i;
  always_comb begin
    if (mag_b == '0 || mag_a < mag_b) k_i = '0;
    else k_i = bitlen(mag_a) - bitlen(mag_b) + IW'(1);
  end

  logic [CW-1:0] lat_i;
  always_comb begin
    if (!div_i)                             lat_i = wide_i ? CW'(MUL_W_LAT) : CW'(MUL_N_LAT);
    else if (DIV_OVH + int'(k_i) < DIV_MIN) lat_i = CW'(DIV_MIN);
    else if (DIV_OVH + int'(k_i) > DIV_MAX) lat_i = CW'(DIV_MAX);
    else                                    lat_i = CW'(DIV_OVH + int'(k_i));
  end

  logic [CW-1:0] cnt;
  logic [IW-1:0] iter;
  logic          div_q, wide_q, ng_a, ng_b, dz;
  logic [W-1:0]  rem, dvs, quo;

  logic [2*W-1:0] prod, pfix;
  assign prod = {{W{1'b0}}, rem} * {{W{1'b0}}, dvs};
  assign pfix = (ng_a ^ ng_b) ? -prod : prod;

  logic [W-1:0] qv, rv, qm, rm;
  assign qv = dz ? '1 : ((ng_a ^ ng_b) ? -quo : quo);
  assign rv = ng_a ? -rem : rem;
  assign qm = wide_q ? qv : (qv & LOMASK);
  assign rm = wide_q ? rv : (rv & LOMASK);

  wire take = start & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      iter   <= '0;
      div_q  <= 1'b0;
      wide_q <= 1'b0;
      ng_a   <= 1'b0;
      ng_b   <= 1'b0;
      dz     <= 1'b0;
      rem    <= '0;
      dvs    <= '0;
      quo    <= '0;
      res_hi <= '0;
      res_lo <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        busy   <= 1'b1;
        cnt    <= lat_i - CW'(1);
        iter   <= div_i ? k_i : '0;
        div_q  <= div_i;
        wide_q <= wide_i;
        ng_a   <= neg_a_i;
        ng_b   <= neg_b_i;
        dz     <= div_i & (mag_b == '0);
        rem    <= mag_a;
        dvs    <= (div_i && k_i != '0) ? (mag_b << (k_i - IW'(1))) : mag_b;
        quo    <= '0;
      end else if (busy) begin
        if (iter != '0) begin
          if (rem >= dvs) begin
            rem <= rem - dvs;
            quo <= {quo[W-2:0], 1'b1};
          end else begin
            quo <= {quo[W-2:0], 1'b0};
          end
          dvs  <= dvs >> 1;
          iter <= iter - IW'(1);
        end
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (div_q) begin
            res_lo <= qm;
            res_hi <= rm;
          end else begin
            res_lo <= pfix[W-1:0];
            res_hi <= wide_q ? pfix[2*W-1:W] : '0;
          end
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(res_lo) || !$stable(res_hi)) |-> done);

  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(div_q) && $stable(wide_q) && $stable(dz)));

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r5_steps_first: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == '0) |-> (iter == '0));

  a_r7_dz_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_q && dz) |-> (res_lo[H-1:0] == {H{1'b1}}));

endmodule

// File: tb/tb_imuldiv_unit.sv
module tb_imuldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        busy, done;
  logic [63:0] res_hi, res_lo;

  imuldiv_unit dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
                    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo));

  always #5 clk = ~clk;

  int vecs = 0, miss = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed { int due; logic [63:0] hi; logic [63:0] lo; } exp_t;
  exp_t  eq[$];
  string tq[$];
  exp_t  cur;
  string ctag;
  logic [63:0] last_hi = '0, last_lo = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    vecs++;
    if (act !== expv) begin
      miss++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (eq.size() != 0 && cyc == eq[0].due) begin
      cur  = eq.pop_front();
      ctag = tq.pop_front();
      chk({ctag, " done at due cycle"}, 64'(done), 64'd1);
      chk({ctag, " res_lo"}, res_lo, cur.lo);
      chk({ctag, " res_hi"}, res_hi, cur.hi);
      last_hi = cur.hi;
      last_lo = cur.lo;
    end else if (done) begin
      chk("R8 unexpected done", 64'(done), 64'd0);
    end
  end

  function automatic int blen(input logic [127:0] v);
    int n = 0;
    for (int i = 0; i < 128; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  task automatic issue(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                       input string tag, input bit intrude);
    logic signed [127:0] xa, xb, p, qq, rr;
    logic [127:0] ma, mb;
    logic [63:0] ehi, elo, mask;
    int k, lat;
    exp_t e;
    bit wide = o[2], sg = o[1], dv = o[0];
    mask = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    if (wide) begin
      xa = sg ? {{64{a[63]}}, a} : {64'b0, a};
      xb = sg ? {{64{b[63]}}, b} : {64'b0, b};
    end else begin
      xa = sg ? {{96{a[31]}}, a[31:0]} : {96'b0, a[31:0]};
      xb = sg ? {{96{b[31]}}, b[31:0]} : {96'b0, b[31:0]};
    end
    if (!dv) begin
      p   = xa * xb;
      elo = p[63:0];
      ehi = wide ? p[127:64] : 64'd0;
      lat = wide ? 6 : 4;
    end else begin
      ma = xa[127] ? -xa : xa;
      mb = xb[127] ? -xb : xb;
      if (xb == 0) begin
        elo = mask;
        ehi = xa[63:0] & mask;
      end else begin
        qq  = xa / xb;
        rr  = xa % xb;
        elo = qq[63:0] & mask;
        ehi = rr[63:0] & mask;
      end
      k   = (mb == 0 || ma < mb) ? 0 : blen(ma) - blen(mb) + 1;
      lat = 9 + k;
      if (lat < 21) lat = 21;
      if (lat > 73) lat = 73;
    end
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    e.due = cyc + 1 + lat; e.hi = ehi; e.lo = elo;
    eq.push_back(e);
    tq.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      @(negedge clk);
      chk("R9 busy during operation", 64'(busy), 64'd1);
      start = 1'b1; op = 3'b000; opa = 64'd3; opb = 64'd5;
      @(negedge clk);
      start = 1'b0;
    end
    while (eq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy after reset", 64'(busy), 64'd0);
    chk("R10 done after reset", 64'(done), 64'd0);
    chk("R10 res_lo after reset", res_lo, 64'd0);
    chk("R10 res_hi after reset", res_hi, 64'd0);

    issue(3'b000, 64'h1234_5678_FFFF_FFFF, 64'hABCD_0000_FFFF_FFFF, "R1 narrow unsigned mul", 0);
    issue(3'b010, 64'h0000_0000_FFFF_FFFD, 64'd7, "R3 narrow signed mul", 0);
    issue(3'b100, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R2 wide unsigned mul", 0);
    issue(3'b110, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, "R3 wide signed mul", 0);
    issue(3'b110, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R3 wide signed min*min", 0);
    issue(3'b001, 64'd100, 64'd7, "R4 R5 narrow divide floor latency", 0);
    issue(3'b001, 64'h0000_0000_FFFF_FFFF, 64'd1, "R5 narrow divide 32 digits", 0);
    issue(3'b101, 64'h8000_0000_0000_0000, 64'd1, "R5 wide divide ceiling", 0);
    issue(3'b101, 64'd3, 64'h0000_0100_0000_0000, "R5 wide divide zero quotient", 0);
    issue(3'b011, 64'h0000_0000_FFFF_FFF9, 64'd2, "R6 signed narrow -7/2", 0);
    issue(3'b111, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, "R6 signed wide 7/-2", 0);
    issue(3'b111, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R6 signed wide min/-1", 0);
    issue(3'b011, 64'h0000_0000_FFFF_FFFB, 64'h1234_5678_0000_0000, "R7 narrow signed divide by zero", 0);
    issue(3'b101, 64'hDEAD_BEEF_0123_4567, 64'd0, "R7 wide unsigned divide by zero", 0);
    issue(3'b101, 64'h0000_0FFF_FFFF_FFFF, 64'd13, "R9 divide with ignored start", 1);
    repeat (3) @(negedge clk);
    chk("R8 res_lo held after done", res_lo, last_lo);
    chk("R8 res_hi held after done", res_hi, last_hi);
    chk("R8 done low after pulse", 64'(done), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule